// File: doc/BRIEF.md
# Mailbox Interrupt Flag Pair

This block keeps the two message-waiting flags that let the two sides of a shared two-port memory signal each other. The two highest word addresses serve as mailboxes. The address just below the top belongs to the left side, and the top address belongs to the right side.

When one side writes into the other side's mailbox, the receiving side's active-low interrupt output is pulled low. When the receiving side reads its own mailbox, its interrupt output is released again. The block watches each side's select, read/write strobe, output enable, address and incoming busy line. It does not hold the message words; those stay in the memory array. All inputs are sampled on the rising clock edge, and the flags are registers, so a qualifying access shows on the outputs one cycle later.

The feature can be turned off by a parameter or by a live enable input. While it is off, both addresses behave as ordinary memory words, and both outputs stay high.

Top module: `mbx_int_pair`

## Requirements
- R1: While reset is asserted, and right after it is released, both `int_l_n` and `int_r_n` are 1 (inactive).
- R2: A right-side write (select low, `r_we_n` low, busy high) to the word at address 2^ADDR_W−2 (0x1FFE by default) drives `int_l_n` to 0 on the next clock.
- R3: A left-side read (select low, `l_we_n` high, `l_oe_n` low, busy high) of address 0x1FFE returns `int_l_n` to 1 on the next clock.
- R4: A left-side write to the top word, 2^ADDR_W−1 (0x1FFF by default), drives `int_r_n` to 0 on the next clock.
- R5: A right-side read of address 0x1FFF returns `int_r_n` to 1 on the next clock.
- R6: Output enable has no effect on a setting write. A read with output enable high does not clear a flag.
- R7: If the acting side's busy input is 0 during a setting write or a clearing read, the flag keeps its value.
- R8: While the feature is off (`mbx_en` = 0 or MAILBOX_ON = 0), both outputs are 1 from the next clock onward, and accesses to either mailbox address have no effect.
- R9: If a set and a clear of the same flag occur in the same cycle, the set wins and the flag becomes 0.
- R10: The other accesses leave both flags unchanged. These are a side writing its own mailbox, a side reading the other side's mailbox, and any access to an address other than the two mailbox words.
- R11: With no qualifying access, each flag holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mbx_en | input | 1 | 1 = mailbox feature in use; 0 = both mailbox words are ordinary memory |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left strobe: 0 = write, 1 = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_busy_n | input | 1 | Left busy, active low; 0 inhibits the left access |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right strobe: 0 = write, 1 = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_busy_n | input | 1 | Right busy, active low; 0 inhibits the right access |
| int_l_n | output | 1 | Left interrupt, active low |
| int_r_n | output | 1 | Right interrupt, active low |

## Verification
Directed accesses are applied to each mailbox from the proper side and from the wrong side. They are repeated with output enable in both states and with busy in both states, which separates the access that really sets or clears a flag from those that only look like one. A same-cycle set and clear of the left flag shows whether the set takes priority. Toggling `mbx_en` while both flags are set shows that the feature can be switched off. A long run of pseudo-random traffic concentrated on the two top addresses then compares both outputs against a behavioural model on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef struct packed {
        logic int_n;
    } flag_st_t;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_req_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int ADDR_W = 13,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    input  logic              en,
    output logic              set_peer,
    output logic              clr_own
);
    logic wr_ok;
    logic rd_ok;

    always_comb begin
        wr_ok    = !cs_n && !we_n && busy_n;
        rd_ok    = !cs_n && we_n && !oe_n && busy_n;
        set_peer = en && wr_ok && (addr == PEER_BOX);
        clr_own  = en && rd_ok && (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  flag_req_t req,
    output logic      int_n
);
    flag_st_t st_d;
    flag_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.int_n = 1'b1;
        end else if (req.set) begin
            st_d.int_n = 1'b0;
        end else if (req.clr) begin
            st_d.int_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{int_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign int_n = st_q.int_n;
endmodule

// File: rtl/mbx_int_pair.sv
module mbx_int_pair
    import mbx_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter bit MAILBOX_ON = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbx_en,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              int_l_n,
    output logic              int_r_n
);
    localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam int NSIDE = 2;

    logic             en;
    logic [NSIDE-1:0] set_from;
    logic [NSIDE-1:0] clr_from;
    flag_req_t        req [NSIDE];
    logic [NSIDE-1:0] flag_n;

    assign en = MAILBOX_ON && mbx_en;

    mbx_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(L_BOX), .PEER_BOX(R_BOX)) u_dec_l (
        .cs_n(l_cs_n), .we_n(l_we_n), .oe_n(l_oe_n), .addr(l_addr),
        .busy_n(l_busy_n), .en(en), .set_peer(set_from[0]), .clr_own(clr_from[0])
    );

    mbx_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(R_BOX), .PEER_BOX(L_BOX)) u_dec_r (
        .cs_n(r_cs_n), .we_n(r_we_n), .oe_n(r_oe_n), .addr(r_addr),
        .busy_n(r_busy_n), .en(en), .set_peer(set_from[1]), .clr_own(clr_from[1])
    );

    // flag i is set by the other side's write and cleared by its own side's read
    for (genvar i = 0; i < NSIDE; i++) begin : g_flag
        always_comb begin
            req[i].set = set_from[NSIDE-1-i];
            req[i].clr = clr_from[i];
        end

        mbx_flag u_flag (
            .clk(clk), .rst_n(rst_n), .en(en), .req(req[i]), .int_n(flag_n[i])
        );
    end

    assign int_l_n = flag_n[0];
    assign int_r_n = flag_n[1];
endmodule

// File: rtl/mbx_int_pair_chk.sv
module mbx_int_pair_chk #(
    parameter int ADDR_W     = 13,
    parameter bit MAILBOX_ON = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mbx_en,
    input logic              l_cs_n,
    input logic              l_we_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_n,
    input logic              r_cs_n,
    input logic              r_we_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_n,
    input logic              int_l_n,
    input logic              int_r_n
);
    localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT = TOP - 1'b1;

    logic on;
    logic sl, cl, sr, cr;
    assign on = MAILBOX_ON && mbx_en;
    assign sl = on && !r_cs_n && !r_we_n && r_busy_n && r_addr == NEXT;
    assign cl = on && !l_cs_n && l_we_n && !l_oe_n && l_busy_n && l_addr == NEXT;
    assign sr = on && !l_cs_n && !l_we_n && l_busy_n && l_addr == TOP;
    assign cr = on && !r_cs_n && r_we_n && !r_oe_n && r_busy_n && r_addr == TOP;

    p_set_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sl |=> !int_l_n);
    p_clear_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cl && !sl) |=> int_l_n);
    p_set_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sr |=> !int_r_n);
    p_clear_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cr && !sr) |=> int_r_n);
    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (int_l_n && int_r_n));
    p_hold_left_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !sl && !cl) |=> $stable(int_l_n));
    p_hold_right_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !sr && !cr) |=> $stable(int_r_n));
endmodule

bind mbx_int_pair mbx_int_pair_chk #(.ADDR_W(ADDR_W), .MAILBOX_ON(MAILBOX_ON)) u_chk (
    .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
    .int_l_n(int_l_n), .int_r_n(int_r_n)
);

// File: tb/test_mbx_int_pair.sv
`timescale 1ns/1ps
module test_mbx_int_pair;
    localparam int AW = 13;
    localparam logic [AW-1:0] LBOX = 13'h1FFE;
    localparam logic [AW-1:0] RBOX = 13'h1FFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mbx_en = 1'b1;
    logic l_cs_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
    logic r_cs_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic int_l_n, int_r_n;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit ref_l = 1'b1, ref_r = 1'b1;
    bit running = 1'b0;

    always #10 clk = ~clk;

    mbx_int_pair i_mbx_int_pair (
        .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
        .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .int_l_n(int_l_n), .int_r_n(int_r_n)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit l_wr, l_rd, r_wr, r_rd, nl, nr;
        l_wr = (l_cs_n == 0) && (l_we_n == 0) && (l_busy_n == 1);
        l_rd = (l_cs_n == 0) && (l_we_n == 1) && (l_oe_n == 0) && (l_busy_n == 1);
        r_wr = (r_cs_n == 0) && (r_we_n == 0) && (r_busy_n == 1);
        r_rd = (r_cs_n == 0) && (r_we_n == 1) && (r_oe_n == 0) && (r_busy_n == 1);
        nl = ref_l;
        nr = ref_r;
        if (l_rd && l_addr == LBOX) nl = 1;
        if (r_wr && r_addr == LBOX) nl = 0;
        if (r_rd && r_addr == RBOX) nr = 1;
        if (l_wr && l_addr == RBOX) nr = 0;
        if (!rst_n || !mbx_en) begin
            nl = 1;
            nr = 1;
        end
        ref_l = nl;
        ref_r = nr;
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (running) begin
            n_cmp++;
            if (int_l_n !== ref_l || int_r_n !== ref_r) begin
                n_bad++;
                $display("FAIL %s (model) l/r actual %b%b expected %b%b at %0t",
                         cur_req, int_l_n, int_r_n, ref_l, ref_r, $time);
            end
        end
    end

    task automatic idle();
        l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = '0;
        r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = '0;
    endtask

    task automatic drive_l(input bit we, input bit oe, input logic [AW-1:0] a, input bit bsy);
        l_cs_n = 0; l_we_n = we; l_oe_n = oe; l_addr = a; l_busy_n = bsy;
    endtask

    task automatic drive_r(input bit we, input bit oe, input logic [AW-1:0] a, input bit bsy);
        r_cs_n = 0; r_we_n = we; r_oe_n = oe; r_addr = a; r_busy_n = bsy;
    endtask

    task automatic launch();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic wait_drive();
        @(negedge clk);
        #2;
    endtask

    task automatic expect_flags(input string req, input bit el, input bit er);
        n_cmp++;
        if (int_l_n !== el || int_r_n !== er) begin
            n_bad++;
            $display("FAIL %s l/r actual %b%b expected %b%b", req, int_l_n, int_r_n, el, er);
        end
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        expect_flags("R1 in reset", 1, 1);
        wait_drive();
        rst_n = 1;
        running = 1;
        @(posedge clk); #1;
        expect_flags("R1 after reset", 1, 1);

        cur_req = "R2";
        wait_drive(); drive_r(0, 1, LBOX, 1); launch();
        expect_flags("R2/R6 right write 1FFE, oe high", 0, 1);

        cur_req = "R10";
        wait_drive(); drive_r(1, 0, LBOX, 1); launch();
        expect_flags("R10 right read of left box", 0, 1);

        cur_req = "R6";
        wait_drive(); drive_l(1, 1, LBOX, 1); launch();
        expect_flags("R6 left read with oe high", 0, 1);

        cur_req = "R7";
        wait_drive(); drive_l(1, 0, LBOX, 0); launch();
        expect_flags("R7 left read while busy", 0, 1);

        cur_req = "R3";
        wait_drive(); drive_l(1, 0, LBOX, 1); launch();
        expect_flags("R3 left read 1FFE", 1, 1);

        cur_req = "R4";
        wait_drive(); drive_l(0, 0, RBOX, 1); launch();
        expect_flags("R4/R6 left write 1FFF, oe low", 1, 0);

        cur_req = "R11";
        repeat (3) @(posedge clk);
        #1;
        expect_flags("R11 hold while idle", 1, 0);

        cur_req = "R7";
        wait_drive(); drive_r(1, 0, RBOX, 0); drive_l(0, 1, 13'h0005, 1); launch();
        expect_flags("R7 right read while busy", 1, 0);
        wait_drive(); drive_r(0, 1, LBOX, 0); launch();
        expect_flags("R7 right write while busy", 1, 0);

        cur_req = "R5";
        wait_drive(); drive_r(1, 0, RBOX, 1); launch();
        expect_flags("R5 right read 1FFF", 1, 1);

        cur_req = "R9";
        wait_drive(); drive_r(0, 1, LBOX, 1); drive_l(1, 0, LBOX, 1); launch();
        expect_flags("R9 set beats clear", 0, 1);
        wait_drive(); drive_l(1, 0, LBOX, 1); launch();
        expect_flags("R3 clear after R9", 1, 1);

        cur_req = "R10";
        wait_drive(); drive_r(0, 1, 13'h1FFD, 1); drive_l(0, 1, 13'h0FFF, 1); launch();
        expect_flags("R10 non-mailbox writes", 1, 1);
        wait_drive(); drive_l(0, 1, LBOX, 1); drive_r(0, 1, RBOX, 1); launch();
        expect_flags("R10 own-box writes", 1, 1);

        cur_req = "R8";
        wait_drive(); drive_r(0, 1, LBOX, 1); drive_l(0, 1, RBOX, 1); launch();
        expect_flags("R2/R4 set both", 0, 0);
        wait_drive(); mbx_en = 0; launch();
        expect_flags("R8 disable releases flags", 1, 1);
        wait_drive(); drive_r(0, 1, LBOX, 1); drive_l(0, 1, RBOX, 1); launch();
        expect_flags("R8 writes ignored while off", 1, 1);
        wait_drive(); mbx_en = 1; launch();
        expect_flags("R8 re-enable stays inactive", 1, 1);

        cur_req = "R11 random";
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                wait_drive();
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                l_cs_n = lfsr[0]; l_we_n = lfsr[1]; l_oe_n = lfsr[2]; l_busy_n = lfsr[3] | lfsr[4];
                l_addr = lfsr[5] ? RBOX : (lfsr[6] ? LBOX : 13'h1FFD);
                r_cs_n = lfsr[7]; r_we_n = lfsr[8]; r_oe_n = lfsr[9]; r_busy_n = lfsr[10] | lfsr[11];
                r_addr = lfsr[12] ? LBOX : (lfsr[13] ? RBOX : 13'h0000);
                mbx_en = (lfsr[14:11] != 4'hF);
            end
            wait_drive();
            idle();
            mbx_en = 1;
            repeat (2) @(posedge clk);
        end

        running = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule